// File: doc/BRIEF.md
# Watchdog Timer with Selectable Tick Resolution

This block is a watchdog peripheral that a processor reaches over a simple 32-bit register bus. Software loads a 16-bit tick count, sets a run bit, and must then keep reloading the counter before it reaches zero. A prescaler turns the core clock into one of four tick periods (32 us, 10 ms, 100 ms or 1 s). The prescaler divides exactly, because it is parameterised by the clock frequency in kHz.

When the countdown expires, the counter stays at zero and a fired flag is latched. The block then issues a single-cycle request, either a reset request or a shutdown request, as selected by a control bit. A configuration input selects the tick resolution, and another configuration input disables the whole watchdog.

A sticky cause bit records that a watchdog reset request was issued. It lives in the power-on reset domain, so it survives the system reset that the request triggers. Software reads it after restart and clears it by writing 1.

Register map (byte offsets, 32-bit words):
- Control at 0x0: bit 0 run, bit 1 fired (write 1 to clear), bit 2 action (1 = shutdown, 0 = reset), bit 3 hardware-disabled status (read only), bits 6:4 reserved, bit 7 reload strobe.
- Count at 0x4: a write sets the reload value; a read returns the live counter.
- Cause at 0x8: bit 1 is the watchdog-reset flag.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control, count and cause registers read 0 and neither request output is high.
- R2: A control write that sets run (bit 0) while the timer is stopped loads the counter from the reload value. The counter then decrements once per tick and expires after as many ticks as were loaded.
- R3: `cfg_res` selects the tick period: 00 = 32 us, 01 = 10 ms, 10 = 100 ms, 11 = 1 s. These correspond to CLK_KHZ*32/1000, CLK_KHZ*10, CLK_KHZ*100 and CLK_KHZ*1000 clock cycles.
- R4: Any change of `cfg_res` restarts the prescaler from zero.
- R5: Writing 1 to control bit 7 reloads the counter from the reload value and restarts the prescaler. Bit 7 always reads as 0.
- R6: A reload while run is clear loads the counter but does not start counting.
- R7: On expiry, the counter holds at 0 and fired (bit 1) is set. Exactly one of `rst_req` (bit 2 = 0) or `shut_req` (bit 2 = 1) pulses high for one clock cycle; the two are never high together.
- R8: Writing 1 to control bit 1 clears the fired flag.
- R9: While `cfg_disable` is high, control bit 3 reads 1, run is held clear and the timer does not count.
- R10: Control bits 6:4 always read 0. Count writes use only bits 15:0, and count reads return the live counter in bits 15:0 with zeros above.
- R11: Cause bit 1 (offset 0x8) is set by a reset request and not by a shutdown request. It survives `rst_n`, and is cleared only by `por_n` or by writing 1 to it.
- R12: Clearing run stops the countdown, and the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| cfg_res | input | 2 | Tick resolution select |
| cfg_disable | input | 1 | Global watchdog disable |
| rst_req | output | 1 | One-cycle reset request on expiry |
| shut_req | output | 1 | One-cycle shutdown request on expiry |

## Verification
The bench times expiry to the exact cycle for several resolutions. A prescaler that is off by one, or that is not restarted by a load, shows up as a request one tick early or late. A resolution glitch in mid-count must push expiry out by the elapsed partial tick; a design that ignores resolution changes fires 22 cycles early. A reload in mid-count must restart the full period, and a reload while stopped must change the counter without ever firing. A design that starts on reload would issue a spurious request. The cause bit is checked across both a system reset and a power-on reset, and it must stay clear after a shutdown expiry; a single reset domain would lose it, and an unqualified set would raise it after a shutdown.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    RES_32US  = 2'b00,
    RES_10MS  = 2'b01,
    RES_100MS = 2'b10,
    RES_1S    = 2'b11
  } wdog_res_e;

  // word indices of the registers (byte address >> 2)
  localparam int unsigned W_CTRL  = 0;
  localparam int unsigned W_COUNT = 1;
  localparam int unsigned W_CAUSE = 2;

  // control bit positions
  localparam int unsigned B_RUN    = 0;
  localparam int unsigned B_FIRED  = 1;
  localparam int unsigned B_SHUT   = 2;
  localparam int unsigned B_HWDIS  = 3;
  localparam int unsigned B_RELOAD = 7;
  localparam int unsigned B_CAUSE  = 1;

  // clock cycles per tick for a resolution code
  function automatic int unsigned res_div(input int unsigned khz, input logic [1:0] sel);
    case (sel)
      2'b00:   res_div = (khz * 32) / 1000;
      2'b01:   res_div = khz * 10;
      2'b10:   res_div = khz * 100;
      default: res_div = khz * 1000;
    endcase
  endfunction

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic [1:0] res_i,
  output logic       tick_o
);
  localparam int unsigned DIV_MAX = res_div(CLK_KHZ, 2'b11);
  localparam int unsigned PC_W    = $clog2(DIV_MAX + 1);

  logic [PC_W-1:0] lim [4];
  logic [PC_W-1:0] pc_q, pc_d;
  logic [1:0]      res_q;
  logic            restart;

  for (genvar g = 0; g < 4; g++) begin : g_lim
    assign lim[g] = PC_W'(res_div(CLK_KHZ, 2'(g)) - 1);
  end

  always_comb begin
    restart = clr_i | (res_i != res_q);
    tick_o  = !restart && (pc_q == lim[res_i]);
    pc_d    = (restart || tick_o) ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      res_q <= RES_32US;
    end else begin
      pc_q  <= pc_d;
      res_q <= res_i;
    end
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             wr_run,
  input  logic             wr_fired_clr,
  input  logic             wr_shut,
  input  logic             wr_reload,
  input  logic [CNT_W-1:0] load_val,
  input  logic             hw_dis,
  input  logic             tick,
  output logic             run,
  output logic             fired,
  output logic             shut,
  output logic [CNT_W-1:0] cnt,
  output logic             presc_clr,
  output logic             rst_req,
  output logic             shut_req
);
  logic             run_q, run_d, fired_q, fired_d, shut_q, shut_d;
  logic             rreq_q, rreq_d, sreq_q, sreq_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start, load, active, step, expire;

  always_comb begin
    start   = ctrl_we & wr_run & ~run_q & ~hw_dis;
    load    = (ctrl_we & wr_reload) | start;
    active  = run_q & ~hw_dis & ~fired_q;
    step    = active & tick & ~load;
    expire  = step & (cnt_q <= CNT_W'(1));
    run_d   = hw_dis ? 1'b0 : (ctrl_we ? wr_run : run_q);
    shut_d  = ctrl_we ? wr_shut : shut_q;
    fired_d = expire ? 1'b1 : ((ctrl_we & wr_fired_clr) ? 1'b0 : fired_q);
    if (load)                          cnt_d = load_val;
    else if (step && cnt_q != '0)      cnt_d = cnt_q - 1'b1;
    else                               cnt_d = cnt_q;
    rreq_d    = expire & ~shut_q;
    sreq_d    = expire & shut_q;
    presc_clr = load | ~active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      fired_q <= 1'b0;
      shut_q  <= 1'b0;
      cnt_q   <= '0;
      rreq_q  <= 1'b0;
      sreq_q  <= 1'b0;
    end else begin
      run_q   <= run_d;
      fired_q <= fired_d;
      shut_q  <= shut_d;
      cnt_q   <= cnt_d;
      rreq_q  <= rreq_d;
      sreq_q  <= sreq_d;
    end
  end

  assign run      = run_q;
  assign fired    = fired_q;
  assign shut     = shut_q;
  assign cnt      = cnt_q;
  assign rst_req  = rreq_q;
  assign shut_req = sreq_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 250000,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        cfg_res,
  input  logic              cfg_disable,
  output logic              rst_req,
  output logic              shut_req
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic              sys_rst_n, por_rst_n;
  logic [WIDX_W-1:0] widx;
  logic              we_ctrl, we_count, we_cause;
  logic [CNT_W-1:0]  reload_q;
  logic              cause_q, cause_d;
  logic              run, fired, shut, presc_clr, tick;
  logic [CNT_W-1:0]  cnt;
  logic              unused_bits;

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_sync (
    .clk(clk), .arst_n(rst_n & por_n), .srst_n(sys_rst_n));
  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk(clk), .arst_n(por_n), .srst_n(por_rst_n));

  always_comb begin
    widx     = bus_addr[ADDR_W-1:2];
    we_ctrl  = bus_sel & bus_wr & (widx == WIDX_W'(W_CTRL));
    we_count = bus_sel & bus_wr & (widx == WIDX_W'(W_COUNT));
    we_cause = bus_sel & bus_wr & (widx == WIDX_W'(W_CAUSE));
    cause_d  = rst_req ? 1'b1 : ((we_cause & bus_wdata[B_CAUSE]) ? 1'b0 : cause_q);
  end

  assign unused_bits = ^{bus_wdata[DATA_W-1:CNT_W], bus_addr[1:0]};

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)    reload_q <= '0;
    else if (we_count) reload_q <= bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) cause_q <= 1'b0;
    else            cause_q <= cause_d;
  end

  wdog_prescaler #(.CLK_KHZ(CLK_KHZ)) u_presc (
    .clk(clk), .rst_n(sys_rst_n), .clr_i(presc_clr), .res_i(cfg_res), .tick_o(tick));

  wdog_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(sys_rst_n), .ctrl_we(we_ctrl),
    .wr_run(bus_wdata[B_RUN]), .wr_fired_clr(bus_wdata[B_FIRED]),
    .wr_shut(bus_wdata[B_SHUT]), .wr_reload(bus_wdata[B_RELOAD]),
    .load_val(reload_q), .hw_dis(cfg_disable), .tick(tick),
    .run(run), .fired(fired), .shut(shut), .cnt(cnt), .presc_clr(presc_clr),
    .rst_req(rst_req), .shut_req(shut_req));

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (widx)
        WIDX_W'(W_CTRL): begin
          bus_rdata[B_RUN]   = run;
          bus_rdata[B_FIRED] = fired;
          bus_rdata[B_SHUT]  = shut;
          bus_rdata[B_HWDIS] = cfg_disable;
        end
        WIDX_W'(W_COUNT): bus_rdata[CNT_W-1:0] = cnt;
        WIDX_W'(W_CAUSE): bus_rdata[B_CAUSE]   = cause_q;
        default:          bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              sys_rst_n,
  input logic              por_rst_n,
  input logic              rst_req,
  input logic              shut_req,
  input logic              fired,
  input logic              run,
  input logic [CNT_W-1:0]  cnt,
  input logic              cfg_disable,
  input logic              cause_q,
  input logic              bus_sel,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata
);
  // R7
  req_excl_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !(rst_req && shut_req));

  // R7
  req_pulse_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (rst_req || shut_req) |=> !(rst_req || shut_req));

  // R7
  req_zero_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (rst_req || shut_req) |-> (cnt == '0 && fired));

  // R9
  dis_run_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    cfg_disable |=> !run);

  // R11
  cause_set_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
    rst_req |=> cause_q);

  // R10
  rsv_read_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (bus_sel && bus_addr[ADDR_W-1:2] == '0) |-> bus_rdata[7:4] == 4'h0);
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .sys_rst_n(sys_rst_n), .por_rst_n(por_rst_n), .rst_req(rst_req),
  .shut_req(shut_req), .fired(fired), .run(run), .cnt(cnt), .cfg_disable(cfg_disable),
  .cause_q(cause_q), .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_rdata(bus_rdata));

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;
  localparam int unsigned KHZ = 1000;  // 32 us tick = 32 cycles

  logic        clk = 1'b0;
  logic        rst_n, por_n, bus_sel, bus_wr, cfg_disable;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  cfg_res;
  logic        rst_req, shut_req;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  wdog_timer #(.CLK_KHZ(KHZ)) u_wdog_timer (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_res(cfg_res), .cfg_disable(cfg_disable), .rst_req(rst_req), .shut_req(shut_req));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic do_reset(input bit por);
    @(negedge clk);
    rst_n = 1'b0;
    if (por) por_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    por_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bw(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic br(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // counts negedges until a request appears; k = limit+1 when none
  task automatic wait_req(input int limit, output int k, output bit r, output bit s);
    k = limit + 1; r = 0; s = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (rst_req || shut_req) begin
        k = i; r = rst_req; s = shut_req;
        break;
      end
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    br(4'h0, d); chk("R1 ctrl", d, 0);
    br(4'h4, d); chk("R1 count", d, 0);
    br(4'h8, d); chk("R1 cause", d, 0);
    chk("R1 rst_req", 32'(rst_req), 0);
    chk("R1 shut_req", 32'(shut_req), 0);
  endtask

  task automatic t_basic();
    logic [31:0] d; int k; bit r, s;
    do_reset(0);
    bw(4'h4, 3); bw(4'h0, 32'h1);
    wait_req(200, k, r, s);
    chk("R2 expiry cycle", k, 96);
    chk("R7 rst_req", 32'(r), 1);
    chk("R7 no shut_req", 32'(s), 0);
    @(negedge clk);
    chk("R7 one-cycle pulse", 32'(rst_req), 0);
    br(4'h4, d); chk("R7 counter at zero", d, 0);
    br(4'h0, d); chk("R7 fired set", d, 32'h3);
    br(4'h8, d); chk("R11 cause set", d, 32'h2);
    bw(4'h0, 32'h3);
    br(4'h0, d); chk("R8 fired cleared", d, 32'h1);
  endtask

  task automatic t_cause();
    logic [31:0] d; int k; bit r, s;
    do_reset(0);
    br(4'h8, d); chk("R11 survives rst_n", d, 32'h2);
    br(4'h0, d); chk("R11 ctrl cleared by rst_n", d, 0);
    bw(4'h8, 32'h2);
    br(4'h8, d); chk("R11 write-1 clear", d, 0);
    bw(4'h4, 1); bw(4'h0, 32'h1);
    wait_req(100, k, r, s);
    chk("R2 one tick", k, 32);
    repeat (2) @(negedge clk);
    br(4'h8, d); chk("R11 set again", d, 32'h2);
    do_reset(1);
    br(4'h8, d); chk("R11 por clears", d, 0);
  endtask

  task automatic t_shut();
    logic [31:0] d; int k; bit r, s;
    do_reset(0);
    bw(4'h4, 2); bw(4'h0, 32'h5);
    wait_req(200, k, r, s);
    chk("R7 shutdown cycle", k, 64);
    chk("R7 shut_req", 32'(s), 1);
    chk("R7 no rst_req", 32'(r), 0);
    repeat (2) @(negedge clk);
    br(4'h8, d); chk("R11 shutdown leaves cause", d, 0);
    br(4'h0, d); chk("R7 ctrl after shutdown", d, 32'h7);
  endtask

  task automatic t_reload();
    logic [31:0] d; int k; bit r, s;
    do_reset(0);
    bw(4'h4, 3); bw(4'h0, 32'h1);
    wait_req(50, k, r, s);
    chk("R5 none before reload", k, 51);
    bw(4'h0, 32'h81);
    br(4'h0, d); chk("R5 reload reads 0", d, 32'h1);
    wait_req(200, k, r, s);
    chk("R5 full period after reload", k, 96);
  endtask

  task automatic t_stopped();
    logic [31:0] d; int k; bit r, s;
    do_reset(0);
    bw(4'h4, 32'hABCD0005);
    br(4'h4, d); chk("R10 live counter unchanged", d, 0);
    bw(4'h0, 32'h80);
    br(4'h4, d); chk("R6 reload while stopped", d, 5);
    wait_req(200, k, r, s);
    chk("R6 no countdown", k, 201);
    br(4'h4, d); chk("R6 counter held", d, 5);
    br(4'h0, d); chk("R6 run stays clear", d, 0);
  endtask

  task automatic t_stop();
    logic [31:0] d; int k; bit r, s;
    do_reset(0);
    bw(4'h4, 3); bw(4'h0, 32'h1);
    wait_req(40, k, r, s);
    bw(4'h0, 32'h0);
    br(4'h4, d); chk("R12 counter after stop", d, 2);
    wait_req(150, k, r, s);
    chk("R12 no expiry", k, 151);
    br(4'h4, d); chk("R12 counter held", d, 2);
  endtask

  task automatic t_disable();
    logic [31:0] d; int k; bit r, s;
    do_reset(0);
    cfg_disable = 1'b1;
    @(negedge clk);
    br(4'h0, d); chk("R9 status bit", d, 32'h8);
    bw(4'h4, 1); bw(4'h0, 32'h1);
    br(4'h0, d); chk("R9 run held clear", d, 32'h8);
    wait_req(100, k, r, s);
    chk("R9 no expiry", k, 101);
    cfg_disable = 1'b0;
  endtask

  task automatic t_res();
    int k; bit r, s;
    do_reset(0);
    cfg_res = 2'b01;
    @(negedge clk);
    bw(4'h4, 1); bw(4'h0, 32'h1);
    wait_req(10100, k, r, s);
    chk("R3 10ms tick", k, 10000);
    do_reset(0);
    cfg_res = 2'b10;
    @(negedge clk);
    bw(4'h4, 1); bw(4'h0, 32'h1);
    wait_req(100100, k, r, s);
    chk("R3 100ms tick", k, 100000);
    do_reset(0);
    cfg_res = 2'b00;
    @(negedge clk);
    bw(4'h4, 1); bw(4'h0, 32'h1);
    repeat (20) @(negedge clk);
    cfg_res = 2'b01;
    @(negedge clk);
    cfg_res = 2'b00;
    wait_req(100, k, r, s);
    chk("R4 restart on resolution change", k, 33);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    do_reset(0);
    bw(4'h0, 32'h000000F0);
    br(4'h0, d); chk("R10 reserved and reload read 0", d, 0);
  endtask

  initial begin
    rst_n = 1'b0; por_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; cfg_res = 2'b00; cfg_disable = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_cause();
    t_shut();
    t_reload();
    t_stopped();
    t_stop();
    t_disable();
    t_reserved();
    t_res();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule